// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block records pending and in-service state for 256 interrupt vectors, as a processor-local interrupt controller does. A sender offers a request as a one-cycle valid strobe with an 8-bit vector number. The block answers in the same cycle: the request is either accepted or refused. The sender never waits for the core, and no handshake follows.

The block keeps one pending bit and one in-service bit per vector. It offers the most urgent pending vector to the core. It moves that vector into service when the core acknowledges, and it retires the most urgent in-service vector on end-of-interrupt. The priority level of a vector is its upper four bits, so each level holds 16 vectors.

A static policy input chooses what happens to a request that cannot be stored as a new occurrence. In merge mode the request is folded into the existing pending bit. In per-vector reject mode it is refused. In per-level reject mode it is also refused once its level already holds its quota of outstanding interrupts.

Top module: `irq_tracker`

## Requirements
- R1: A request for a vector below 16 (0x00 to 0x0F) is refused under every policy. Vector 0x10 is the lowest legal vector.
- R2: With policy code 0 (merge) or code 3, a legal request is never refused. A request for a vector that is already pending sets nothing new, so one acknowledge serves all merged requests.
- R3: With policy code 1 (per-vector reject), a legal request is refused exactly when the vector's pending bit is set.
- R4: With policy code 2 (per-level reject), a legal request is refused when its vector is already pending, or when the pending plus in-service bits of its level (vector bits 7:4) number two or more.
- R5: `req_reject_o` is combinational from the current inputs and state. It is high only while `req_valid_i` is high.
- R6: The offered vector is the pending vector of highest level, and the higher vector number within a level. `irq_vec_o` reads 0 while `irq_o` is low.
- R7: `irq_o` is high only when the top pending level is strictly above the top in-service level, or when nothing is in service.
- R8: On an acknowledge while `irq_o` is high, the offered vector's pending bit clears and its in-service bit sets at the same edge. An acknowledge while `irq_o` is low has no effect. A request in the same cycle for the acknowledged vector is admitted against the cleared pending bit and is recorded pending again.
- R9: End-of-interrupt clears the in-service bit of the highest in-service vector.
- R10: Reset (asynchronous, active low) clears all pending and in-service bits, so `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Overflow policy: 0 merge, 1 per-vector reject, 2 per-level reject, 3 merge |
| req_valid_i | input | 1 | Request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_reject_o | output | 1 | Request refused (same cycle) |
| irq_o | output | 1 | A vector is offered to the core |
| irq_vec_o | output | 8 | Offered vector, 0 when none |
| ack_i | input | 1 | Core accepts the offered vector |
| eoi_i | input | 1 | Core finishes the top in-service vector |

## Verification
A wrong pending bit shows up as early as the next cycle. It appears at `irq_vec_o` when that vector is the most urgent one, or at `req_reject_o` when a second request for it arrives. A wrong in-service bit is often hidden until the cycle after an end-of-interrupt exposes the next level, where `irq_o` either fails to rise or rises too early. For this reason the bench follows each acknowledge and end-of-interrupt with idle cycles that observe the offer, and it probes the admission decisions with repeated requests to the same vector and to the same level.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  typedef enum logic [1:0] {
    POL_MERGE   = 2'd0,
    POL_VEC_REJ = 2'd1,
    POL_LVL_REJ = 2'd2,
    POL_SPARE   = 2'd3
  } policy_e;
endpackage

// File: rtl/irqt_prio_find.sv
module irqt_prio_find #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // Ascending scan: the last set bit seen (highest index) wins.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqt_admit.sv
module irqt_admit
  import irqt_pkg::*;
#(
  parameter int N        = 256,
  parameter int LVL_SZ   = 16,
  parameter int NUM_RSVD = 16,
  parameter int LVL_CAP  = 2,
  parameter int IW       = $clog2(N),
  parameter int LW       = $clog2(LVL_SZ)
) (
  input  policy_e       pol_i,
  input  logic          valid_i,
  input  logic [IW-1:0] vec_i,
  input  logic [N-1:0]  pend_view_i,
  input  logic [N-1:0]  ins_view_i,
  output logic          reject_o,
  output logic          accept_o
);
  localparam int CW = $clog2(2 * LVL_SZ + 1);

  logic [IW-LW-1:0] lvl;
  logic [CW-1:0]    lvl_cnt;
  logic             illegal;
  logic             slot_busy;
  logic             refuse;

  assign lvl       = vec_i[IW-1:LW];
  assign illegal   = vec_i < IW'(NUM_RSVD);
  assign slot_busy = pend_view_i[vec_i];

  // Occupancy of the request's priority level: pending plus in-service.
  always_comb begin
    logic [IW-1:0] idx;
    lvl_cnt = '0;
    for (int j = 0; j < LVL_SZ; j++) begin
      idx     = {lvl, LW'(j)};
      lvl_cnt = lvl_cnt + CW'(pend_view_i[idx]) + CW'(ins_view_i[idx]);
    end
  end

  always_comb begin
    refuse = illegal;
    unique case (pol_i)
      POL_VEC_REJ: if (slot_busy) refuse = 1'b1;
      POL_LVL_REJ: if (slot_busy || (lvl_cnt >= CW'(LVL_CAP))) refuse = 1'b1;
      default:     ;
    endcase
  end

  assign reject_o = valid_i && refuse;
  assign accept_o = valid_i && !refuse;
endmodule

// File: rtl/irq_tracker.sv
module irq_tracker
  import irqt_pkg::*;
#(
  parameter int NUM_VEC  = 256,
  parameter int LVL_SZ   = 16,
  parameter int NUM_RSVD = 16,
  parameter int LVL_CAP  = 2,
  localparam int IW      = $clog2(NUM_VEC),
  localparam int LW      = $clog2(LVL_SZ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    policy_i,
  input  logic          req_valid_i,
  input  logic [IW-1:0] req_vec_i,
  output logic          req_reject_o,
  output logic          irq_o,
  output logic [IW-1:0] irq_vec_o,
  input  logic          ack_i,
  input  logic          eoi_i
);
  policy_e pol;
  assign pol = policy_e'(policy_i);

  logic [NUM_VEC-1:0] pend_q, pend_d, ins_q, ins_d;
  logic [NUM_VEC-1:0] ack_mask, eoi_mask, set_mask;
  logic [NUM_VEC-1:0] pend_view, ins_view;
  logic               p_any, i_any;
  logic [IW-1:0]      p_idx, i_idx;
  logic [IW-LW-1:0]   p_lvl, i_lvl;
  logic               offer, take, accept, upd_en;

  irqt_prio_find #(.N(NUM_VEC), .IW(IW)) pend_find_i (
    .bits_i(pend_q), .any_o(p_any), .idx_o(p_idx));

  irqt_prio_find #(.N(NUM_VEC), .IW(IW)) ins_find_i (
    .bits_i(ins_q), .any_o(i_any), .idx_o(i_idx));

  assign p_lvl = p_idx[IW-1:LW];
  assign i_lvl = i_idx[IW-1:LW];

  // Offer only when the top pending level beats the top in-service level.
  assign offer     = p_any && (!i_any || (p_lvl > i_lvl));
  assign irq_o     = offer;
  assign irq_vec_o = offer ? p_idx : '0;
  assign take      = ack_i && offer;

  always_comb begin
    ack_mask = '0;
    eoi_mask = '0;
    if (take)           ack_mask[p_idx] = 1'b1;
    if (eoi_i && i_any) eoi_mask[i_idx] = 1'b1;
  end

  // Admission sees the state with this cycle's acknowledge already applied.
  assign pend_view = pend_q & ~ack_mask;
  assign ins_view  = ins_q | ack_mask;

  irqt_admit #(
    .N(NUM_VEC), .LVL_SZ(LVL_SZ), .NUM_RSVD(NUM_RSVD),
    .LVL_CAP(LVL_CAP), .IW(IW), .LW(LW)
  ) admit_i (
    .pol_i(pol), .valid_i(req_valid_i), .vec_i(req_vec_i),
    .pend_view_i(pend_view), .ins_view_i(ins_view),
    .reject_o(req_reject_o), .accept_o(accept));

  always_comb begin
    set_mask = '0;
    if (accept) set_mask[req_vec_i] = 1'b1;
  end

  assign pend_d = pend_view | set_mask;
  assign ins_d  = (ins_q & ~eoi_mask) | ack_mask;
  assign upd_en = req_valid_i || take || (eoi_i && i_any);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ins_q  <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      ins_q  <= ins_d;
    end
  end

  // R5
  rej_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject_o |-> req_valid_i);

  // R1
  illegal_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (req_vec_i < IW'(NUM_RSVD))) |-> req_reject_o);

  // R2
  merge_no_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (pol == POL_MERGE) && (req_vec_i >= IW'(NUM_RSVD)))
      |-> !req_reject_o);

  // R3
  vec_free_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (pol == POL_VEC_REJ) && (req_vec_i >= IW'(NUM_RSVD))
      && !pend_q[req_vec_i]) |-> !req_reject_o);

  // R8
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> ins_q[$past(irq_vec_o)]);

  // R9
  eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && i_any) |=> !ins_q[$past(i_idx)]);
endmodule

// File: tb/irq_tracker_tb.sv
module irq_tracker_tb_top;
  typedef struct packed {
    logic [3:0] rq;
    logic [1:0] pol;
    logic       v;
    logic [7:0] vec;
    logic       ack;
    logic       eoi;
    logic       erej;
    logic       eirq;
    logic [7:0] evec;
  } step_t;

  // rq pol v vec ack eoi erej eirq evec ; outputs are checked before the edge
  localparam step_t TBL [0:28] = '{
    '{4'd2,  2'd0, 1'b1, 8'h35, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 first request
    '{4'd2,  2'd0, 1'b1, 8'h35, 1'b0, 1'b0, 1'b0, 1'b1, 8'h35}, // R2 merge
    '{4'd8,  2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h35}, // R8 ack
    '{4'd2,  2'd0, 1'b1, 8'h35, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 one pending one in service
    '{4'd7,  2'd0, 1'b1, 8'h35, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R7 same level blocked
    '{4'd7,  2'd0, 1'b1, 8'h52, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R7
    '{4'd6,  2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h52}, // R6 higher level
    '{4'd8,  2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h52}, // R8
    '{4'd9,  2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R9 eoi top (0x52)
    '{4'd9,  2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R9 eoi 0x35
    '{4'd7,  2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h35}, // R7 unblocked
    '{4'd8,  2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h35}, // R8
    '{4'd3,  2'd1, 1'b1, 8'h35, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 accept
    '{4'd3,  2'd1, 1'b1, 8'h35, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}, // R3 refuse
    '{4'd1,  2'd1, 1'b1, 8'h0A, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}, // R1 illegal
    '{4'd9,  2'd1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R9
    '{4'd4,  2'd2, 1'b1, 8'h36, 1'b0, 1'b0, 1'b0, 1'b1, 8'h35}, // R4 level count 1
    '{4'd4,  2'd2, 1'b1, 8'h3F, 1'b0, 1'b0, 1'b1, 1'b1, 8'h36}, // R4 level full, R6 in-level
    '{4'd4,  2'd2, 1'b1, 8'h60, 1'b1, 1'b0, 1'b0, 1'b1, 8'h36}, // R4 other level, R8 ack
    '{4'd4,  2'd2, 1'b1, 8'h3A, 1'b0, 1'b0, 1'b1, 1'b1, 8'h60}, // R4 pending+in-service full
    '{4'd2,  2'd0, 1'b1, 8'h3A, 1'b0, 1'b0, 1'b0, 1'b1, 8'h60}, // R2 merge accepts
    '{4'd1,  2'd0, 1'b1, 8'h05, 1'b0, 1'b0, 1'b1, 1'b1, 8'h60}, // R1 in merge mode
    '{4'd8,  2'd0, 1'b1, 8'h60, 1'b1, 1'b0, 1'b0, 1'b1, 8'h60}, // R8 ack + re-request
    '{4'd7,  2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R7 level 6 in service
    '{4'd8,  2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R8 ack ignored
    '{4'd9,  2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R9 clears 0x60
    '{4'd8,  2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h60}, // R8 re-pended vector offered
    '{4'd8,  2'd1, 1'b1, 8'h60, 1'b1, 1'b0, 1'b0, 1'b1, 8'h60}, // R8 admit on post-ack view
    '{4'd3,  2'd1, 1'b1, 8'h60, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}  // R3 refuse
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] policy_i;
  logic       req_valid_i;
  logic [7:0] req_vec_i;
  logic       req_reject_o;
  logic       irq_o;
  logic [7:0] irq_vec_o;
  logic       ack_i;
  logic       eoi_i;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  irq_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .policy_i(policy_i),
    .req_valid_i(req_valid_i), .req_vec_i(req_vec_i),
    .req_reject_o(req_reject_o), .irq_o(irq_o), .irq_vec_o(irq_vec_o),
    .ack_i(ack_i), .eoi_i(eoi_i));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] pol, input logic v, input logic [7:0] vec,
                       input logic ack, input logic eoi);
    @(negedge clk);
    policy_i = pol; req_valid_i = v; req_vec_i = vec; ack_i = ack; eoi_i = eoi;
    #8;
  endtask

  initial begin
    rst_n = 1'b0; policy_i = 2'd0; req_valid_i = 1'b0; req_vec_i = 8'h00;
    ack_i = 1'b0; eoi_i = 1'b0;
    repeat (3) @(negedge clk);
    #8;
    check("R10", "irq in reset", {31'd0, irq_o}, 32'd0);
    check("R6", "vec in reset", {24'd0, irq_vec_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (TBL[i]) begin
      string tag;
      tag = $sformatf("R%0d", TBL[i].rq);
      drive(TBL[i].pol, TBL[i].v, TBL[i].vec, TBL[i].ack, TBL[i].eoi);
      check(tag, $sformatf("step %0d reject", i), {31'd0, req_reject_o}, {31'd0, TBL[i].erej});
      check(tag, $sformatf("step %0d irq", i), {31'd0, irq_o}, {31'd0, TBL[i].eirq});
      check(tag, $sformatf("step %0d vec", i), {24'd0, irq_vec_o}, {24'd0, TBL[i].evec});
    end

    // R10: asynchronous reset in mid-run clears the pending 0x60
    drive(2'd0, 1'b0, 8'h00, 1'b0, 1'b1);
    drive(2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R10", "offer before reset", {31'd0, irq_o}, 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R10", "irq during reset", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R10", "irq after reset", {31'd0, irq_o}, 32'd0);

    // R5: no strobe, no refusal even for an illegal vector
    drive(2'd2, 1'b0, 8'h05, 1'b0, 1'b0);
    check("R5", "reject without valid", {31'd0, req_reject_o}, 32'd0);

    // R1 boundary: 0x0F refused, 0x10 accepted
    drive(2'd2, 1'b1, 8'h0F, 1'b0, 1'b0);
    check("R1", "vector 0x0F", {31'd0, req_reject_o}, 32'd1);
    drive(2'd2, 1'b1, 8'h10, 1'b0, 1'b0);
    check("R1", "vector 0x10", {31'd0, req_reject_o}, 32'd0);
    drive(2'd3, 1'b1, 8'h10, 1'b0, 1'b0);
    check("R2", "policy 3 merges", {31'd0, req_reject_o}, 32'd0);
    drive(2'd0, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R6", "lowest legal vector offered", {24'd0, irq_vec_o}, 32'h10);
    drive(2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R2", "merged request gone after one ack", {31'd0, irq_o}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule